// File: doc/BRIEF.md
# Bus-cycle-stepped SPI master port

This block is an SPI master for an 8-bit processor bus of the Z80 kind. It has no clock divider and no bit counter. The processor's own bus cycles set the serial clock. An I/O access to the port drives the serial clock low. The refresh slot of the next opcode fetch drives it high again and shifts one MISO bit into the shift register. The port answers anywhere in the upper half of the I/O space, which is every address with A7 high.

Software sends a byte by writing it to an even port address, which loads the shift register and starts the first bit. It then reads the even address seven times and the odd address once. Each read returns the shift register on the data bus and puts the next outgoing bit on MOSI. A read at an even address also starts the next bit. The read at the odd address finishes the last bit and leaves the clock high. If an interrupt arrives between accesses, the clock stays high with MOSI and the captured bit held, so the transfer resumes safely when the next access comes.

All bus strobes are sampled on the system clock `clk`. The clock phase input `phi` chooses whether a strobe condition lowers or raises the serial clock.

Top module: `spiBusPort`

## Requirements
- R1: After reset, `sclk` is 1, `mosi` is 0, the shift register is 0 and `rdEn` is 0.
- R2: An I/O access with `a7` = 0 has no effect on `sclk`, `mosi` or the shift register, and `rdEn` stays 0 during it.
- R3: A port write (`ioreqN`=0, `wrN`=0, `a7`=1, `m1N`=1) loads the shift register from `dataIn` and sets `mosi` to `dataIn[7]`.
- R4: `sclk` goes low in the clock after a port access samples `phi`=0 with `a0`=0.
- R5: While `sclk` is low, a cycle with `mreqN`=0, `rfshN`=0 and `phi`=1 drives `sclk` high. The same cycle shifts the shift register one place toward bit 7 and puts `miso` into bit 0. Transfers are MSB first.
- R6: A refresh cycle while `sclk` is already high does not shift the register and does not change `sclk`.
- R7: During a port read (`rdN`=0), `rdEn` is 1 and `rdData` equals the shift register. The read also sets `mosi` to shift register bit 7.
- R8: A port access with `a0` = 1 never lowers `sclk`. A read at the odd address therefore finishes a byte and leaves the clock high.
- R9: An interrupt acknowledge cycle (`ioreqN`=0 with `m1N`=0) is ignored: `rdEn` stays 0 and `sclk`, `mosi` and the shift register are unchanged.
- R10: Between accesses, with no port access and no refresh while `sclk` is low, `sclk`, `mosi` and the shift register hold their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| ioreqN | input | 1 | I/O request strobe, active low |
| mreqN | input | 1 | Memory request strobe, active low |
| rfshN | input | 1 | Refresh strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| m1N | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| phi | input | 1 | Processor clock phase level |
| a0 | input | 1 | Address bit 0: 0 starts a new bit, 1 does not |
| a7 | input | 1 | Address bit 7: 1 selects the port |
| dataIn | input | 8 | Data bus value during writes |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data to the slave |
| rdData | output | 8 | Shift register contents during a port read, 0 otherwise |
| rdEn | output | 1 | Data bus drive enable for port reads |

## Verification
The bench runs full bytes in several bit patterns and checks MOSI after every step. A design that took MOSI from the wrong end of the register, or shifted MISO into the wrong bit, fails there. The closing read at the odd address must leave the clock high; a design that ignored A0 would start a ninth edge. The bench also drives a refresh while the clock is already high, which must not shift, and an interrupt acknowledge aimed at the port, which a design without the M1 qualifier would answer. It also drives a write with A7 low and a long idle stretch after a rising edge; a design with weak decode or hold would corrupt the register or the clock level in these cases.

// File: rtl/spiBusPkg.sv
package spiBusPkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic load;      // take parallel data from the bus
    logic shift;     // rising serial clock: shift and capture
    logic txUpdate;  // port read: refresh serial output
  } spiStrobes_t;
endpackage

// File: rtl/spiBusCtrl.sv
module spiBusCtrl
  import spiBusPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioreqN,
  input  logic        mreqN,
  input  logic        rfshN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        m1N,
  input  logic        phi,
  input  logic        a0,
  input  logic        a7,
  output spiStrobes_t strb,
  output logic        sclk,
  output logic        rdEn
);
  logic portSel;
  logic clkLowCond;
  logic clkHighCond;
  logic sclkQ;

  // port decode: upper half of I/O space, never an interrupt acknowledge
  assign portSel     = !ioreqN && m1N && a7;
  assign clkLowCond  = portSel && !phi && !a0;
  assign clkHighCond = !mreqN && !rfshN && phi && !sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sclkQ <= 1'b1;
    else if (clkLowCond)  sclkQ <= 1'b0;
    else if (clkHighCond) sclkQ <= 1'b1;
  end

  always_comb begin
    strb.load     = portSel && !wrN;
    strb.shift    = clkHighCond;
    strb.txUpdate = portSel && !rdN;
  end

  assign sclk = sclkQ;
  assign rdEn = portSel && !rdN;

  // R5
  sclk_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $past(!mreqN && !rfshN && phi));

  // R4
  sclk_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $past(!ioreqN && a7 && !a0 && !phi && m1N));

  // R9
  intack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ioreqN && !m1N && mreqN) |=> $stable(sclk));
endmodule

// File: rtl/spiShiftPath.sv
module spiShiftPath
  import spiBusPkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  spiStrobes_t  strb,
  input  logic [W-1:0] dataIn,
  input  logic         miso,
  output logic [W-1:0] shiftReg,
  output logic         mosi
);
  localparam int MSB = W - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      mosi     <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= dataIn;
      mosi     <= dataIn[MSB];
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[MSB-1:0], miso};
    end else if (strb.txUpdate) begin
      mosi <= shiftReg[MSB];
    end
  end

  // R3
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (shiftReg == $past(dataIn)) && (mosi == $past(dataIn[MSB])));

  // R5
  shift_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.shift && !strb.load) |=>
      (shiftReg[0] == $past(miso)) && (shiftReg[MSB:1] == $past(shiftReg[MSB-1:0])));

  // R10
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.txUpdate) |=> $stable(mosi));

  // R10
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(shiftReg));
endmodule

// File: rtl/spiBusPort.sv
module spiBusPort
  import spiBusPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioreqN,
  input  logic              mreqN,
  input  logic              rfshN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              m1N,
  input  logic              phi,
  input  logic              a0,
  input  logic              a7,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEn
);
  spiStrobes_t       strb;
  logic [DATA_W-1:0] shiftReg;

  spiBusCtrl uCtrl (
    .clk(clk), .rstN(rstN), .ioreqN(ioreqN), .mreqN(mreqN), .rfshN(rfshN),
    .rdN(rdN), .wrN(wrN), .m1N(m1N), .phi(phi), .a0(a0), .a7(a7),
    .strb(strb), .sclk(sclk), .rdEn(rdEn)
  );

  spiShiftPath #(.W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .miso(miso),
    .shiftReg(shiftReg), .mosi(mosi)
  );

  assign rdData = rdEn ? shiftReg : '0;

  // R7
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> (rdData == '0));
endmodule

// File: tb/tb_spiBusPort.sv
module tb_spiBusPort;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // each entry: {byte sent, byte the slave returns}
  localparam logic [15:0] VEC [NVEC] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic ioreqN = 1, mreqN = 1, rfshN = 1, rdN = 1, wrN = 1, m1N = 1;
  logic phi = 1, a0 = 0, a7 = 0, miso = 0;
  logic [7:0] dataIn = '0;
  logic sclk, mosi, rdEn;
  logic [7:0] rdData;
  logic [7:0] lastData;
  logic lastOe;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiBusPort dut (
    .clk(clk), .rstN(rstN), .ioreqN(ioreqN), .mreqN(mreqN), .rfshN(rfshN),
    .rdN(rdN), .wrN(wrN), .m1N(m1N), .phi(phi), .a0(a0), .a7(a7),
    .dataIn(dataIn), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rdData(rdData), .rdEn(rdEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one I/O cycle: phi high, phi low, phi high (bus sampled), release
  task automatic ioAccess(input bit isWrite, input bit a7v, input bit a0v,
                          input bit m1v, input logic [7:0] d);
    @(negedge clk);
    ioreqN = 0; a7 = a7v; a0 = a0v; m1N = m1v; dataIn = d; phi = 1;
    if (isWrite) wrN = 0; else rdN = 0;
    @(negedge clk); phi = 0;
    @(negedge clk); phi = 1;
    lastOe = rdEn; lastData = rdData;
    @(negedge clk);
    ioreqN = 1; rdN = 1; wrN = 1; m1N = 1; a7 = 0; a0 = 0;
  endtask

  task automatic refresh(input logic bitIn);
    @(negedge clk); miso = bitIn; mreqN = 0; rfshN = 0; phi = 0;
    @(negedge clk); phi = 1;
    @(negedge clk); mreqN = 1; rfshN = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 1'b0, 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx, rx, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sclk", {7'd0, sclk}, 8'd1);
    check("R1 mosi", {7'd0, mosi}, 8'd0);
    check("R1 rdEn", {7'd0, rdEn}, 8'd0);
    rstN = 1;
    ioAccess(0, 1, 1, 1, 8'h00);
    check("R1 shift register", lastData, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      tx = VEC[v][15:8]; rx = VEC[v][7:0];
      ioAccess(1, 1, 0, 1, tx);
      check("R3 mosi after write", {7'd0, mosi}, {7'd0, tx[7]});
      check("R4 sclk low after write", {7'd0, sclk}, 8'd0);
      for (int b = 0; b < 8; b++) begin
        refresh(rx[7-b]);
        check("R5 sclk high after refresh", {7'd0, sclk}, 8'd1);
        if (b < 7) begin
          ioAccess(0, 1, 0, 1, 8'h00);
          check("R7 mosi after read", {7'd0, mosi}, {7'd0, tx[6-b]});
          check("R4 sclk low after even read", {7'd0, sclk}, 8'd0);
        end else begin
          ioAccess(0, 1, 1, 1, 8'h00);
          check("R8 sclk stays high after odd read", {7'd0, sclk}, 8'd1);
          check("R7 rdEn", {7'd0, lastOe}, 8'd1);
          check("R5 received byte", lastData, rx);
        end
      end
    end
    held = VEC[NVEC-1][7:0];

    // R2: write with A7 low ignored; read with A7 low not driven
    ioAccess(1, 0, 0, 1, 8'h11);
    check("R2 sclk", {7'd0, sclk}, 8'd1);
    ioAccess(0, 0, 0, 1, 8'h00);
    check("R2 rdEn", {7'd0, lastOe}, 8'd0);
    ioAccess(0, 1, 1, 1, 8'h00);
    check("R2 register unchanged", lastData, held);

    // R6: refresh while sclk high does nothing
    refresh(1'b1);
    check("R6 sclk", {7'd0, sclk}, 8'd1);
    ioAccess(0, 1, 1, 1, 8'h00);
    check("R6 register unshifted", lastData, held);

    // R9: interrupt acknowledge aimed at the port
    ioAccess(0, 1, 0, 0, 8'h00);
    check("R9 rdEn", {7'd0, lastOe}, 8'd0);
    check("R9 sclk", {7'd0, sclk}, 8'd1);

    // R8: write at odd address loads without lowering sclk
    ioAccess(1, 1, 1, 1, 8'h80);
    check("R8 sclk after odd write", {7'd0, sclk}, 8'd1);
    check("R8 mosi after odd write", {7'd0, mosi}, 8'd1);
    ioAccess(0, 1, 1, 1, 8'h00);
    check("R8 register loaded", lastData, 8'h80);

    // R10: interrupted transfer holds state
    ioAccess(1, 1, 0, 1, 8'h40);
    refresh(1'b1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); mreqN = 0; phi = i[0];
    end
    @(negedge clk); mreqN = 1;
    check("R10 sclk held", {7'd0, sclk}, 8'd1);
    check("R10 mosi held", {7'd0, mosi}, 8'd0);
    ioAccess(0, 1, 1, 1, 8'h00);
    check("R10 register held", lastData, 8'h81);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule